// File: doc/BRIEF.md
# Noise-Adaptive Decoder Strength Controller

This block closes the loop between a channel decoder and the logic that reloads it. For every decoded bit it receives a valid strobe with two energy figures: one for the signal and one for the noise. It sums both figures over a fixed window of valid bits. At the end of each window it grades the signal-to-noise ratio against an ascending set of ratio thresholds. It does this with constant multiplies, so no divider is needed. The grade selects the decoder strength from a table, and a cleaner channel selects a smaller, cheaper setting.

A reload costs a long outage, so the block asks for one only when the selected strength differs from the one already loaded. It raises a one-cycle request that carries the new strength. It then stops sampling until the reload mechanism signals completion. Only then does it update the published active strength and open a fresh window. The window length, energy width, thresholds and strength table are parameters. The default window is 250,000 bits.

Top module: `snr_reconfig_ctrl`

## Requirements
- R1: After reset, `nmax_o` and `cfg_nmax_o` both equal table entry 0, which is the largest strength (default 15), and `cfg_req_o` is low.
- R2: A window closes on the clock edge that samples its `WINDOW_BITS`-th bit with `bit_valid_i` high. Cycles with `bit_valid_i` low neither count nor add energy.
- R3: With window sums S (signal) and N (noise), the grade is the number of thresholds t for which S >= N*t. With defaults t = {2, 4, 16} the grades are 0..3, and they map to strengths {15, 9, 5, 3}. Equality counts as reaching a threshold, and N = 0 gives the top grade.
- R4: `cfg_req_o` is high for exactly one cycle: the cycle after the one that follows the closing edge. It rises only when the selected strength differs from `nmax_o`, and `cfg_nmax_o` then carries the selected strength.
- R5: `nmax_o` changes only on the edge that samples `cfg_done_i` high while a reload is pending. It then takes the requested value, and the next window starts.
- R6: Bits that arrive from the closing edge until the completion edge are ignored. They are neither counted nor summed.
- R7: `cfg_done_i` has no effect when no reload is pending.
- R8: Each window starts from zero sums and a zero count, so its grade depends only on its own bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_valid_i | input | 1 | A decoded bit is present this cycle |
| sig_energy_i | input | E_W | Signal energy of the bit |
| noise_energy_i | input | E_W | Noise energy of the bit |
| cfg_req_o | output | 1 | One-cycle reload request |
| cfg_nmax_o | output | NMAX_W | Strength requested for the reload |
| cfg_done_i | input | 1 | Reload complete |
| nmax_o | output | NMAX_W | Strength currently loaded |

## Verification
The closing bit is sampled on edge k. The request is due after edge k+1, and it has fallen again after edge k+2. The active strength moves on the edge that samples done. The bench drives inputs on falling edges and reads outputs on the next falling edge, stepping exactly that number of edges before each comparison. To show that a window has not closed early, it checks that the request stays low at both edges where a close would have shown. This is done after one bit short of a window that contains idle cycles, and after bits injected during a pending reload.

// File: rtl/snr_pkg.sv
package snr_pkg;
  typedef enum logic [1:0] {
    ST_SAMPLE = 2'd0,
    ST_EVAL   = 2'd1,
    ST_REQ    = 2'd2,
    ST_WAIT   = 2'd3
  } ctrl_state_e;
endpackage

// File: rtl/snr_window_acc.sv
module snr_window_acc #(
  parameter int unsigned WINDOW_BITS = 250000,
  parameter int unsigned E_W         = 8,
  localparam int unsigned CNT_W      = $clog2(WINDOW_BITS),
  localparam int unsigned ACC_W      = E_W + $clog2(WINDOW_BITS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             valid_i,
  input  logic [E_W-1:0]   sig_i,
  input  logic [E_W-1:0]   noise_i,
  output logic             close_o,
  output logic [ACC_W-1:0] sig_tot_o,
  output logic [ACC_W-1:0] noise_tot_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [ACC_W-1:0] sig_acc_q, noise_acc_q;
  logic [ACC_W-1:0] sig_nxt, noise_nxt;
  logic             take;

  assign take      = en_i & valid_i;
  assign close_o   = take && (cnt_q == CNT_W'(WINDOW_BITS - 1));
  assign sig_nxt   = sig_acc_q + ACC_W'(sig_i);
  assign noise_nxt = noise_acc_q + ACC_W'(noise_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      sig_acc_q   <= '0;
      noise_acc_q <= '0;
      sig_tot_o   <= '0;
      noise_tot_o <= '0;
    end else if (close_o) begin
      cnt_q       <= '0;
      sig_acc_q   <= '0;
      noise_acc_q <= '0;
      sig_tot_o   <= sig_nxt;
      noise_tot_o <= noise_nxt;
    end else if (take) begin
      cnt_q       <= cnt_q + 1'b1;
      sig_acc_q   <= sig_nxt;
      noise_acc_q <= noise_nxt;
    end
  end
endmodule

// File: rtl/snr_level_map.sv
module snr_level_map #(
  parameter int unsigned ACC_W   = 26,
  parameter int unsigned NUM_LVL = 4,
  parameter int unsigned TH_W    = 8,
  parameter int unsigned NMAX_W  = 4,
  parameter logic [NUM_LVL-2:0][TH_W-1:0]   THR_TBL  = {8'd16, 8'd4, 8'd2},
  parameter logic [NUM_LVL-1:0][NMAX_W-1:0] NMAX_TBL = {4'd3, 4'd5, 4'd9, 4'd15},
  localparam int unsigned LVL_W  = $clog2(NUM_LVL),
  localparam int unsigned PROD_W = ACC_W + TH_W
) (
  input  logic [ACC_W-1:0]  sig_tot_i,
  input  logic [ACC_W-1:0]  noise_tot_i,
  output logic [NMAX_W-1:0] nmax_sel_o
);
  logic [NUM_LVL-2:0] hit;
  logic [LVL_W-1:0]   lvl;

  // ratio test by cross multiply: S >= N*t
  for (genvar g = 0; g < NUM_LVL - 1; g++) begin : g_thr
    assign hit[g] = PROD_W'(sig_tot_i) >= (PROD_W'(noise_tot_i) * PROD_W'(THR_TBL[g]));
  end

  always_comb begin
    lvl = '0;
    for (int i = 0; i < NUM_LVL - 1; i++) lvl = lvl + LVL_W'(hit[i]);
  end

  assign nmax_sel_o = NMAX_TBL[lvl];
endmodule

// File: rtl/snr_ctrl_fsm.sv
module snr_ctrl_fsm
  import snr_pkg::*;
#(
  parameter int unsigned NMAX_W    = 4,
  parameter logic [NMAX_W-1:0] NMAX_RST = 4'd15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              close_i,
  input  logic [NMAX_W-1:0] nmax_sel_i,
  input  logic              done_i,
  output ctrl_state_e       state_o,
  output logic              req_o,
  output logic [NMAX_W-1:0] target_o,
  output logic [NMAX_W-1:0] nmax_o
);
  ctrl_state_e state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_SAMPLE;
      target_o <= NMAX_RST;
      nmax_o   <= NMAX_RST;
    end else begin
      unique case (state_q)
        ST_SAMPLE: if (close_i) state_q <= ST_EVAL;
        ST_EVAL: begin
          if (nmax_sel_i != nmax_o) begin
            target_o <= nmax_sel_i;
            state_q  <= ST_REQ;
          end else begin
            state_q <= ST_SAMPLE;
          end
        end
        ST_REQ:  state_q <= ST_WAIT;
        ST_WAIT: begin
          if (done_i) begin
            nmax_o  <= target_o;
            state_q <= ST_SAMPLE;
          end
        end
        default: state_q <= ST_SAMPLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign req_o   = (state_q == ST_REQ);
endmodule

// File: rtl/snr_reconfig_ctrl.sv
module snr_reconfig_ctrl
  import snr_pkg::*;
#(
  parameter int unsigned WINDOW_BITS = 250000,
  parameter int unsigned E_W         = 8,
  parameter int unsigned NUM_LVL     = 4,
  parameter int unsigned TH_W        = 8,
  parameter int unsigned NMAX_W      = 4,
  parameter logic [NUM_LVL-2:0][TH_W-1:0]   THR_TBL  = {8'd16, 8'd4, 8'd2},
  parameter logic [NUM_LVL-1:0][NMAX_W-1:0] NMAX_TBL = {4'd3, 4'd5, 4'd9, 4'd15},
  localparam int unsigned ACC_W = E_W + $clog2(WINDOW_BITS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_valid_i,
  input  logic [E_W-1:0]    sig_energy_i,
  input  logic [E_W-1:0]    noise_energy_i,
  output logic              cfg_req_o,
  output logic [NMAX_W-1:0] cfg_nmax_o,
  input  logic              cfg_done_i,
  output logic [NMAX_W-1:0] nmax_o
);
  ctrl_state_e      state;
  logic             win_close;
  logic [ACC_W-1:0] sig_tot, noise_tot;
  logic [NMAX_W-1:0] nmax_sel;

  snr_window_acc #(
    .WINDOW_BITS(WINDOW_BITS),
    .E_W        (E_W)
  ) u_acc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (state == ST_SAMPLE),
    .valid_i    (bit_valid_i),
    .sig_i      (sig_energy_i),
    .noise_i    (noise_energy_i),
    .close_o    (win_close),
    .sig_tot_o  (sig_tot),
    .noise_tot_o(noise_tot)
  );

  snr_level_map #(
    .ACC_W   (ACC_W),
    .NUM_LVL (NUM_LVL),
    .TH_W    (TH_W),
    .NMAX_W  (NMAX_W),
    .THR_TBL (THR_TBL),
    .NMAX_TBL(NMAX_TBL)
  ) u_map (
    .sig_tot_i  (sig_tot),
    .noise_tot_i(noise_tot),
    .nmax_sel_o (nmax_sel)
  );

  snr_ctrl_fsm #(
    .NMAX_W  (NMAX_W),
    .NMAX_RST(NMAX_TBL[0])
  ) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .close_i   (win_close),
    .nmax_sel_i(nmax_sel),
    .done_i    (cfg_done_i),
    .state_o   (state),
    .req_o     (cfg_req_o),
    .target_o  (cfg_nmax_o),
    .nmax_o    (nmax_o)
  );
endmodule

// File: rtl/snr_reconfig_ctrl_chk.sv
module snr_reconfig_ctrl_chk
  import snr_pkg::*;
#(
  parameter int unsigned NMAX_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_req_o,
  input logic [NMAX_W-1:0] cfg_nmax_o,
  input logic              cfg_done_i,
  input logic [NMAX_W-1:0] nmax_o,
  input logic              win_close,
  input ctrl_state_e       state
);
  p_req_one_cycle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o |=> !cfg_req_o);

  p_req_differs_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o |-> (cfg_nmax_o != nmax_o));

  p_req_after_eval_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_req_o) |-> ($past(state) == ST_EVAL));

  p_nmax_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(state == ST_WAIT && cfg_done_i) |=> $stable(nmax_o));

  p_nmax_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_WAIT && cfg_done_i) |=> (nmax_o == $past(cfg_nmax_o)));

  p_no_close_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state != ST_SAMPLE) |-> !win_close);

  p_done_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_SAMPLE && cfg_done_i) |=> $stable(nmax_o));
endmodule

bind snr_reconfig_ctrl snr_reconfig_ctrl_chk #(.NMAX_W(NMAX_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cfg_req_o (cfg_req_o),
  .cfg_nmax_o(cfg_nmax_o),
  .cfg_done_i(cfg_done_i),
  .nmax_o    (nmax_o),
  .win_close (win_close),
  .state     (state)
);

// File: tb/snr_reconfig_ctrl_tb.sv
module snr_reconfig_ctrl_tb;
  localparam int unsigned W = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid = 1'b0;
  logic [7:0] sig = '0;
  logic [7:0] noise = '0;
  logic       done = 1'b0;
  logic       req;
  logic [3:0] req_nmax;
  logic [3:0] nmax;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  snr_reconfig_ctrl #(.WINDOW_BITS(W)) u_dut (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .bit_valid_i   (valid),
    .sig_energy_i  (sig),
    .noise_energy_i(noise),
    .cfg_req_o     (req),
    .cfg_nmax_o    (req_nmax),
    .cfg_done_i    (done),
    .nmax_o        (nmax)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // drive cnt valid bits from a falling edge; gap inserts an idle junk cycle after each
  task automatic send_bits(input int cnt, input int s, input int n, input bit gap);
    for (int i = 0; i < cnt; i++) begin
      valid = 1'b1; sig = 8'(s); noise = 8'(n);
      @(negedge clk);
      if (gap) begin
        valid = 1'b0; sig = 8'hff; noise = 8'h00;
        @(negedge clk);
      end
    end
    valid = 1'b0; sig = '0; noise = '0;
  endtask

  // after the closing edge: check request timing and payload
  task automatic expect_req(input string tag, input int exp_nmax, input int old_nmax);
    chk({tag, " R4 no req in eval"}, int'(req), 0);
    @(negedge clk);
    chk({tag, " R4 req pulse"}, int'(req), 1);
    chk({tag, " R3 req value"}, int'(req_nmax), exp_nmax);
    chk({tag, " R5 nmax before done"}, int'(nmax), old_nmax);
    @(negedge clk);
    chk({tag, " R4 req dropped"}, int'(req), 0);
  endtask

  task automatic expect_no_req(input string tag, input int cur);
    chk({tag, " R4 no req a"}, int'(req), 0);
    @(negedge clk);
    chk({tag, " R4 no req b"}, int'(req), 0);
    chk({tag, " R5 nmax kept"}, int'(nmax), cur);
    @(negedge clk);
  endtask

  task automatic complete(input string tag, input int delay, input int old_nmax,
                          input int new_nmax, input bit junk);
    for (int i = 0; i < delay; i++) begin
      if (junk) begin valid = 1'b1; sig = 8'd200; noise = 8'd0; end
      @(negedge clk);
      chk({tag, " R5 nmax held while pending"}, int'(nmax), old_nmax);
    end
    valid = 1'b0; sig = '0; noise = '0;
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    chk({tag, " R5 nmax loaded"}, int'(nmax), new_nmax);
  endtask

  task automatic t_reset();
    chk("R1 nmax reset", int'(nmax), 15);
    chk("R1 req_nmax reset", int'(req_nmax), 15);
    chk("R1 req low", int'(req), 0);
  endtask

  task automatic t_idle_done();
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    @(negedge clk);
    chk("R7 done idle nmax", int'(nmax), 15);
    chk("R7 done idle req", int'(req), 0);
  endtask

  task automatic t_gapped_window();
    send_bits(W - 1, 100, 1, 1'b1);
    chk("R2 short window a", int'(req), 0);
    @(negedge clk);
    chk("R2 short window b", int'(req), 0);
    send_bits(1, 100, 1, 1'b0);
    expect_req("R2 gapped", 3, 15);
    complete("R2 gapped", 7, 15, 3, 1'b0);
  endtask

  task automatic t_same();
    send_bits(W, 100, 1, 1'b0);
    expect_no_req("R4 same", 3);
  endtask

  task automatic t_ignore_busy();
    send_bits(W, 30, 10, 1'b0);
    expect_req("R6 mid", 9, 3);
    complete("R6 mid", 5, 3, 9, 1'b1);
    send_bits(W - 1, 10, 10, 1'b0);
    chk("R6 window held a", int'(req), 0);
    @(negedge clk);
    chk("R6 window held b", int'(req), 0);
    send_bits(1, 10, 10, 1'b0);
    expect_req("R8 fresh low", 15, 9);
    complete("R8 fresh low", 3, 9, 15, 1'b0);
  endtask

  task automatic t_boundary();
    send_bits(W, 40, 10, 1'b0);
    expect_req("R3 equal thr", 5, 15);
    complete("R3 equal thr", 2, 15, 5, 1'b0);
    send_bits(W, 39, 10, 1'b0);
    expect_req("R3 below thr", 9, 5);
    complete("R3 below thr", 2, 5, 9, 1'b0);
    send_bits(W, 5, 0, 1'b0);
    expect_req("R3 zero noise", 3, 9);
    complete("R3 zero noise", 1, 9, 3, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle_done();
    t_gapped_window();
    t_same();
    t_ignore_busy();
    t_boundary();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule